// File: doc/BRIEF.md
# Execute-in-Place Quad Serial Flash Read Sequencer

This block sits on the host side of a four-line serial flash bus and turns read requests into bus transactions. A request carries a byte address, a byte count and the value of the mode-keep bit. The block lowers chip select and clocks out the read opcode when needed. It then sends the address four bits per clock and a configurable run of dummy clocks, and gathers the returned data nibbles into bytes. Each byte leaves on a valid/ready stream.

The flash can stay in a continuous-read state where it expects no opcode. The sequencer keeps its own copy of that state. The mode-keep bit goes out on line 0 during the first dummy clock: 0 keeps the flash in the opcode-less state and 1 sends it back to ordinary reads. The copy is updated from that bit when the transaction ends. A synchronous reset loads the copy from a static input that mirrors the flash's power-up setting. This lets the first read after power-up already use the opcode-less form.

The serial clock runs at half the system clock and idles low. It stops whenever a finished byte is still waiting at the output. Chip select stays high for a minimum number of system clocks between transactions.

Top module: `xip_read_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, out_valid is 0, req_ready is 1, and xip_active equals cfg_xip_default.
- R2: When xip_active is 0, a transaction begins with the 8-bit opcode 0xEB, most significant bit first, one bit per serial clock on line 0 (spi_dq_oe = 4'b0001).
- R3: When xip_active is 1, the first serial clock after chip select falls already carries address bits, and no opcode is sent.
- R4: The 24-bit address follows on all four lines (spi_dq_oe = 4'b1111), one nibble per clock, most significant nibble first, with bit 3 of the nibble on line 3.
- R5: In the first dummy clock, line 0 carries req_exit_xip as latched with the request, and only line 0 is driven (spi_dq_oe = 4'b0001). During the remaining dummy clocks and all data clocks no line is driven.
- R6: The number of dummy clocks equals cfg_dummy (1 to 15). A value of 0 gives one dummy clock.
- R7: Data lines are sampled on rising serial clock edges, two nibbles per byte with the high nibble first. Exactly req_len+1 bytes are delivered in address order on out_data, and out_data stays stable while out_valid is high and out_ready is low.
- R8: When a transaction ends, xip_active becomes 1 if the latched mode-keep bit was 0, and becomes 0 if it was 1. The next transaction sends or omits the opcode accordingly.
- R9: While a byte waits at the output (out_valid high, out_ready low) during the data phase, spi_sclk does not rise.
- R10: Between two transactions, spi_cs_n stays high for at least CS_GAP (default 4) system clocks.
- R11: spi_sclk is 0 whenever spi_cs_n is 1 (clock idles low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; reloads the continuous-read state |
| cfg_dummy | input | 4 | Dummy clock count, 0 treated as 1 |
| cfg_xip_default | input | 1 | Continuous-read state loaded at reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 24 | Start byte address |
| req_len | input | 8 | Number of bytes minus one |
| req_exit_xip | input | 1 | Mode-keep bit for this read: 1 leaves the continuous-read state |
| out_valid | output | 1 | Read byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Read byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_dq_out | output | 4 | Values driven on data lines |
| spi_dq_oe | output | 4 | Per-line output enable |
| spi_dq_in | input | 4 | Values sampled from data lines |
| xip_active | output | 1 | Flash is believed to be in the continuous-read state |

## Verification
A behavioural flash model decodes every transaction edge by edge. It keeps its own copy of the continuous-read state and returns an address-derived byte pattern. The reads cover both opcode and opcode-less starts, entry into and exit from the continuous-read state, and a reset that loads an enabled default. Together these show whether the state copy, rather than a fixed format, decides the opcode. Dummy settings of 0, 1, 8 and 15 show off-by-one errors in the dummy run, which shift every data nibble. A read under a ready pattern that stalls three cycles in four shows whether the clock is really held. Back-to-back requests measure the chip-select gap.

// File: rtl/xip_seq_pkg.sv
package xip_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA
  } xip_phase_e;
endpackage

// File: rtl/xip_mode_track.sv
module xip_mode_track (
  input  logic clk,
  input  logic rst,
  input  logic nv_default_i,
  input  logic done_i,
  input  logic confirm_i,
  output logic active_o
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) active_q <= nv_default_i;
    else if (done_i) active_q <= ~confirm_i;
  end

  assign active_o = active_q;

  // R8: state follows the mode-keep bit of the finished read
  assert_mode_update_R8: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (active_o == !$past(confirm_i)));
endmodule

// File: rtl/xip_cs_gap.sv
module xip_cs_gap #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_rise_i,
  output logic idle_ok_o
);
  localparam int CW = $clog2(GAP + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cs_rise_i) cnt_q <= CW'(GAP);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign idle_ok_o = (cnt_q == '0);
endmodule

// File: rtl/xip_read_seq.sv
module xip_read_seq
  import xip_seq_pkg::*;
#(
  parameter int         ADDR_W  = 24,
  parameter int         LEN_W   = 8,
  parameter int         DUMMY_W = 4,
  parameter int         CS_GAP  = 4,
  parameter logic [7:0] READ_OP = 8'hEB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DUMMY_W-1:0] cfg_dummy,
  input  logic               cfg_xip_default,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_exit_xip,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic [3:0]         spi_dq_out,
  output logic [3:0]         spi_dq_oe,
  input  logic [3:0]         spi_dq_in,
  output logic               xip_active
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int CNT_W    = $clog2(ADDR_NIB + 8 + (1 << DUMMY_W));

  xip_phase_e         st_q;
  logic               cs_n_q, sclk_q, nib_q, conf_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LEN_W-1:0]   byte_q, len_q;
  logic [7:0]         cmd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DUMMY_W-1:0] dum_q;
  logic [3:0]         hinib_q;
  logic               out_valid_q;
  logic [7:0]         out_data_q;
  logic               idle_ok, start, done, may_rise;

  assign req_ready = (st_q == PH_IDLE) && idle_ok;
  assign start     = req_ready && req_valid;
  assign done      = (st_q == PH_DATA) && sclk_q && nib_q && (byte_q == len_q);
  assign may_rise  = (st_q != PH_DATA) || !out_valid_q || out_ready;

  xip_mode_track u_track (
    .clk          (clk),
    .rst          (rst),
    .nv_default_i (cfg_xip_default),
    .done_i       (done),
    .confirm_i    (conf_q),
    .active_o     (xip_active)
  );

  xip_cs_gap #(.GAP(CS_GAP)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .cs_rise_i (done),
    .idle_ok_o (idle_ok)
  );

  always_comb begin
    spi_dq_out = 4'b0;
    spi_dq_oe  = 4'b0;
    unique case (st_q)
      PH_CMD: begin
        spi_dq_out = {3'b0, cmd_q[7]};
        spi_dq_oe  = 4'b0001;
      end
      PH_ADDR: begin
        spi_dq_out = addr_q[ADDR_W-1 -: 4];
        spi_dq_oe  = 4'b1111;
      end
      PH_DUMMY: begin
        if (cnt_q == '0) begin
          spi_dq_out = {3'b0, conf_q};
          spi_dq_oe  = 4'b0001;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PH_IDLE;
      cs_n_q      <= 1'b1;
      sclk_q      <= 1'b0;
      nib_q       <= 1'b0;
      conf_q      <= 1'b0;
      cnt_q       <= '0;
      byte_q      <= '0;
      len_q       <= '0;
      cmd_q       <= '0;
      addr_q      <= '0;
      dum_q       <= '0;
      hinib_q     <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (out_valid_q && out_ready) out_valid_q <= 1'b0;
      if (st_q == PH_IDLE) begin
        if (start) begin
          cs_n_q <= 1'b0;
          cnt_q  <= '0;
          nib_q  <= 1'b0;
          byte_q <= '0;
          len_q  <= req_len;
          addr_q <= req_addr;
          conf_q <= req_exit_xip;
          cmd_q  <= READ_OP;
          dum_q  <= (cfg_dummy == '0) ? DUMMY_W'(1) : cfg_dummy;
          st_q   <= xip_active ? PH_ADDR : PH_CMD;
        end
      end else if (!sclk_q) begin
        if (may_rise) begin
          sclk_q <= 1'b1;
          if (st_q == PH_DATA) begin
            if (!nib_q) hinib_q <= spi_dq_in;
            else begin
              out_data_q  <= {hinib_q, spi_dq_in};
              out_valid_q <= 1'b1;
            end
          end
        end
      end else begin
        sclk_q <= 1'b0;
        unique case (st_q)
          PH_CMD: begin
            if (cnt_q == CNT_W'(7)) begin
              st_q  <= PH_ADDR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
              cmd_q <= {cmd_q[6:0], 1'b0};
            end
          end
          PH_ADDR: begin
            if (cnt_q == CNT_W'(ADDR_NIB - 1)) begin
              st_q  <= PH_DUMMY;
              cnt_q <= '0;
            end else begin
              cnt_q  <= cnt_q + CNT_W'(1);
              addr_q <= {addr_q[ADDR_W-5:0], 4'b0};
            end
          end
          PH_DUMMY: begin
            if (cnt_q + CNT_W'(1) == CNT_W'(dum_q)) begin
              st_q  <= PH_DATA;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_DATA: begin
            nib_q <= ~nib_q;
            if (nib_q) begin
              if (byte_q == len_q) begin
                st_q   <= PH_IDLE;
                cs_n_q <= 1'b1;
              end else begin
                byte_q <= byte_q + LEN_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  // R11: clock idles low whenever the flash is deselected
  assert_idle_clk_R11: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);
  // R9: no rising clock edge while a byte waits
  assert_stall_clk_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_DATA) && out_valid_q && !out_ready |=> !$rose(sclk_q));
  // R7: waiting byte is held
  assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid_q && !out_ready |=> out_valid_q && $stable(out_data_q));
  // R5: data lines released in the data phase
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_DATA) |-> (spi_dq_oe == 4'b0));
  // R10: chip select stays high after a transaction
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |=> cs_n_q);
  // R3: opcode-less start when the state is active
  assert_no_opcode_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) && xip_active |-> (st_q == PH_ADDR));
endmodule

// File: tb/xip_read_seq_tb.sv
module xip_read_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_dummy = 4'd8;
  logic        cfg_xip_default = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_exit_xip = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        spi_cs_n, spi_sclk;
  logic [3:0]  spi_dq_out, spi_dq_oe, spi_dq_in;
  logic        xip_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  xip_read_seq u_dut (
    .clk(clk), .rst(rst), .cfg_dummy(cfg_dummy), .cfg_xip_default(cfg_xip_default),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_exit_xip(req_exit_xip), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_dq_out(spi_dq_out), .spi_dq_oe(spi_dq_oe), .spi_dq_in(spi_dq_in),
    .xip_active(xip_active)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // flash model state
  logic        m_xip = 1'b0, had_op = 1'b0, m_conf = 1'b0;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_ov = 1'b0, prev_or = 1'b1;
  logic [7:0]  m_op = '0;
  logic [23:0] m_addr = '0;
  logic [3:0]  m_nib = '0;
  int          rc = 0, fc = 0, m_dum = 8, hi_run = 0, gap_last = 0;
  bit          oe_bad = 0, stall_bad = 0, mode_bad = 0;

  assign spi_dq_in = m_nib;

  always @(negedge clk) begin
    if (rst) begin
      m_xip = cfg_xip_default; prev_cs = 1'b1; prev_sclk = 1'b0; hi_run = 100;
      m_nib = '0;
    end else begin
      if (spi_cs_n && spi_sclk) mode_bad = 1;
      if (prev_ov && !prev_or && !prev_sclk && spi_sclk) stall_bad = 1;
      if (prev_cs && !spi_cs_n) begin
        rc = 0; fc = 0; had_op = !m_xip; m_op = '0; m_addr = '0; m_conf = 1'b0;
        oe_bad = 0; gap_last = hi_run;
      end
      if (spi_cs_n) hi_run++; else hi_run = 0;
      if (!spi_cs_n && !prev_sclk && spi_sclk) begin
        if (had_op && rc < 8) begin
          m_op = {m_op[6:0], spi_dq_out[0]};
          if (spi_dq_oe != 4'b0001) oe_bad = 1;
        end else begin
          int a;
          a = rc - (had_op ? 8 : 0);
          if (a < 6) begin
            m_addr = {m_addr[19:0], spi_dq_out};
            if (spi_dq_oe != 4'b1111) oe_bad = 1;
          end else if (a == 6) begin
            m_conf = spi_dq_out[0];
            if (spi_dq_oe != 4'b0001) oe_bad = 1;
          end else if (spi_dq_oe != 4'b0000) oe_bad = 1;
        end
        rc++;
      end
      if (!spi_cs_n && prev_sclk && !spi_sclk) fc++;
      if (!prev_cs && spi_cs_n) m_xip = !m_conf;
      begin
        int ds;
        ds = (had_op ? 8 : 0) + 6 + m_dum;
        if (!spi_cs_n && fc >= ds) begin
          int j;
          logic [7:0] b;
          j = fc - ds;
          b = pat(m_addr + 24'(j / 2));
          m_nib = (j % 2 == 1) ? b[3:0] : b[7:4];
        end else m_nib = '0;
      end
      prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_ov = out_valid; prev_or = out_ready;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dflt);
    @(posedge clk); #1;
    cfg_xip_default = dflt; rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_read(input logic [23:0] a, input int nb, input logic conf,
                         input logic [3:0] dcfg, input bit stall, input bit exp_op);
    logic [7:0] got [0:15];
    int n = 0, k = 0, bad = 0, exp_rc;
    cfg_dummy = dcfg; m_dum = (dcfg == 0) ? 1 : int'(dcfg);
    stall_bad = 0;
    req_addr = a; req_len = 8'(nb - 1); req_exit_xip = conf; req_valid = 1'b1;
    forever begin
      bit r;
      r = req_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    req_valid = 1'b0;
    while (n < nb || !spi_cs_n) begin
      out_ready = stall ? ((k % 4) == 3) : 1'b1;
      if (out_valid && out_ready && n < 16) begin got[n] = out_data; n++; end
      k++;
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    if (exp_op) begin
      check(had_op == 1'b1, "R2 opcode present", had_op, 1);
      check(m_op == 8'hEB, "R2 opcode value", m_op, 8'hEB);
    end else begin
      check(had_op == 1'b0, "R3 opcode omitted", had_op, 0);
    end
    check(m_addr == a, "R4 address", m_addr, a);
    check(m_conf == conf, "R5 mode-keep bit", m_conf, conf);
    check(oe_bad == 0, "R5 line enables", oe_bad, 0);
    exp_rc = (exp_op ? 8 : 0) + 6 + m_dum + 2 * nb;
    check(rc == exp_rc, "R6 clock count", rc, exp_rc);
    for (int i = 0; i < nb; i++) if (got[i] != pat(a + 24'(i))) bad++;
    check(bad == 0 && n == nb, "R7 data bytes", bad, 0);
    check(stall_bad == 0, "R9 clock held", stall_bad, 0);
    check(mode_bad == 0, "R11 clock idle low", mode_bad, 0);
    check(xip_active == !conf, "R8 state update", xip_active, !conf);
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    check(spi_cs_n == 1'b1, "R1 cs high", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1 sclk low", spi_sclk, 0);
    check(out_valid == 1'b0, "R1 no valid", out_valid, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(xip_active == 1'b0, "R1 default off", xip_active, 0);
  endtask

  task automatic t_enter_and_stay;
    do_read(24'h123456, 3, 1'b0, 4'd8, 0, 1);
    do_read(24'hABCDEF, 2, 1'b0, 4'd1, 0, 0);
  endtask

  task automatic t_stall;
    do_read(24'h00F0F0, 7, 1'b0, 4'd15, 1, 0);
  endtask

  task automatic t_exit;
    do_read(24'h777000, 1, 1'b1, 4'd8, 0, 0);
    do_read(24'h777010, 2, 1'b1, 4'd0, 0, 1);
  endtask

  task automatic t_gap;
    do_read(24'h010203, 1, 1'b0, 4'd2, 0, 1);
    do_read(24'h040506, 1, 1'b0, 4'd2, 0, 0);
    check(gap_last >= 4, "R10 cs gap", gap_last, 4);
  endtask

  task automatic t_nv_default;
    do_reset(1'b1);
    check(xip_active == 1'b1, "R1 default on", xip_active, 1);
    do_read(24'h3C3C00, 2, 1'b0, 4'd6, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_enter_and_stay();
    t_stall();
    t_exit();
    t_gap();
    t_nv_default();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule